// File: doc/BRIEF.md
# Disk Attachment Interrupt Service Engine

This block sits on the host side of a disk controller attachment and handles one interrupt at a time without software help. A pulse on `irq_evt` starts it. It first reads the attachment's busy/status register to confirm that the interrupt really belongs to this attachment. It then reads the interrupt status register to learn which interrupt type was raised and for which drive. Next it drains the variable-length status block from the status interface register, one 16-bit word at a time. After that it takes the follow-up action that the interrupt type selects.

Depending on the type, the follow-up is one of four things: enabling the DMA path on the attachment, recording a completed command, recording a failed command, or latching a fatal condition. Most types end with an end-of-interrupt attention handshake, addressed to the same drive, that re-arms the attachment. For read and write commands the engine captures the residual block count from the status block. It also exposes the stored status words for the host.

All attachment accesses use a simple single-cycle register port. A read returns data in the same cycle it is requested, and a read of the interrupt status or status interface register consumes that register on the clock edge.

Top module: `dskint_handler`

## Requirements
- R1: After synchronous reset, `busy`, `cmd_done`, `cmd_fail`, `fatal`, `len_ovf`, `resid`, `last_dev`, `last_id` and all of `stat_blk` are zero, and no register access is made.
- R2: When `irq_evt` arrives while bit 0 (interrupt pending) of the status register (address 0) reads 0, the engine makes no read of the interrupt status register (address 1), makes no write, and changes none of its outputs.
- R3: The interrupt status register carries the drive number in bits 7:5 and the interrupt type in bits 3:0. For an accepted interrupt, these appear on `last_dev` and `last_id`.
- R4: Interrupt types 0, 2 and 4 are spurious. After such an interrupt status read, no status word is read, nothing is written, and `last_dev`, `last_id`, `stat_blk`, `cmd_done`, `cmd_fail` and `resid` keep their values.
- R5: After an accepted interrupt status read, `stat_blk` is cleared. If bit 2 (status word ready) of the status register is then set, the first word is read from address 2. Its bits 15:8 give the block length L (0 counts as 1) and its bits 4:0 give the command code. L-1 further words are read, each only after bit 2 reads 1. Word i is stored at `stat_blk[16*i +: 16]` for i < 8, and unused slots stay zero.
- R6: When L exceeds 8, all L words are still drained, only the first 8 are kept, and `len_ovf` is set. `len_ovf` is cleared by the next accepted interrupt.
- R7: Type 11 (transfer ready) writes 0x0003 (interrupt enable in bit 0, DMA enable in bit 1) to the control register (address 3). It makes no other write and leaves `cmd_done`, `cmd_fail` and `resid` unchanged.
- R8: Types 1, 3, 5 and 8 (completions) set `cmd_done` to 1 and `cmd_fail` to 0.
- R9: Types 9 (abort done) and 10 (reset done) leave `cmd_done` and `cmd_fail` unchanged but still perform the end-of-interrupt handshake.
- R10: Type 15 (attention error) sets `fatal`, which stays 1 until reset. This type makes no write.
- R11: Every other type (6, 7, 12, 13, 14) sets `cmd_fail` to 1 and `cmd_done` to 0.
- R12: The end-of-interrupt handshake has four steps in order. It writes 0 to the control register. It then waits until bit 1 (busy) of the status register reads 0; this wait is skipped for type 10. It writes {drive, 5'd2} into bits 7:0 of the attention register (address 4). Finally it writes 0x0001 to the control register.
- R13: If the command code is 1 (read) or 2 (write) and the type is not 11, `resid` takes status word 2 (zero when L < 3). Otherwise `resid` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_evt | input | 1 | One-cycle interrupt event from the attachment line |
| att_rd | output | 1 | Register read strobe toward the attachment |
| att_wr | output | 1 | Register write strobe toward the attachment |
| att_addr | output | 3 | Register select |
| att_wdata | output | 16 | Write data |
| att_rdata | input | 16 | Read data, valid in the cycle of `att_rd` |
| busy | output | 1 | Engine is servicing an event |
| cmd_done | output | 1 | Last status-changing interrupt was a completion |
| cmd_fail | output | 1 | Last status-changing interrupt was a failure |
| fatal | output | 1 | Attention error seen since reset |
| len_ovf | output | 1 | Last status block was longer than the store |
| resid | output | 16 | Residual block count of the last read/write command |
| last_dev | output | 3 | Drive number of the last accepted interrupt |
| last_id | output | 4 | Type of the last accepted interrupt |
| stat_blk | output | 128 | Stored status words, word i in bits 16*i+15:16*i |

## Verification
The bench targets several corner cases:

- **Status word arrival.** The attachment holds back each following status word by a few cycles. An engine that reads without polling the ready bit would take stale words and miscompare `stat_blk`.
- **Block length.** Lengths of 0, 1, 2, 8, 9 and 11 cover the zero-means-one rule, the residual coming from a zero-filled slot, and overflow. An engine that stops draining at 8 words would leave the port unread and show a short SIFR read count.
- **Handshake differences.** Reset-done is issued while the attachment is still busy, so a wrongly placed busy poll shows up as a late attention write. Transfer-ready and attention error are checked for the absence of any attention write.
- **Ignored inputs.** Spurious types and a cleared pending bit are checked for untouched outputs and for no extra register reads.

// File: rtl/dskint_pkg.sv
// Package: register addresses, bit positions, interrupt type codes and the
// action classes shared by the interrupt service engine and its helpers.
// Assumes a 16-bit attachment data path with byte-wide command fields.
package dskint_pkg;

    // Attachment register selects
    localparam logic [2:0] RA_STATUS = 3'd0;   // busy/status register
    localparam logic [2:0] RA_ISR    = 3'd1;   // interrupt status register
    localparam logic [2:0] RA_SWORD  = 3'd2;   // status word port
    localparam logic [2:0] RA_CTRL   = 3'd3;   // control register
    localparam logic [2:0] RA_ATTN   = 3'd4;   // attention register

    // Status register bit positions
    localparam int SB_PEND  = 0;
    localparam int SB_BUSY  = 1;
    localparam int SB_READY = 2;

    // Interrupt type codes
    localparam logic [3:0] ID_OK        = 4'd1;
    localparam logic [3:0] ID_OK_ECC    = 4'd3;
    localparam logic [3:0] ID_OK_RETRY  = 4'd5;
    localparam logic [3:0] ID_WARN      = 4'd8;
    localparam logic [3:0] ID_ABORTED   = 4'd9;
    localparam logic [3:0] ID_RESET     = 4'd10;
    localparam logic [3:0] ID_XFER_RDY  = 4'd11;
    localparam logic [3:0] ID_ATTN_ERR  = 4'd15;

    // Command codes that carry a residual block count
    localparam logic [4:0] CMD_READ  = 5'd1;
    localparam logic [4:0] CMD_WRITE = 5'd2;

    // Attention code for end of interrupt
    localparam logic [4:0] ATTN_EOI = 5'd2;

    // Control register values
    localparam logic [7:0] CTRL_IEN = 8'h01;
    localparam logic [7:0] CTRL_DMA = 8'h02;

    // Status block word that holds the residual block count
    localparam int RESID_WORD = 2;

    typedef enum logic [2:0] {
        ACT_SPURIOUS,
        ACT_DMA,
        ACT_DONE,
        ACT_QUIET,
        ACT_FATAL,
        ACT_FAIL
    } act_e;

endpackage

// File: rtl/dskint_classify.sv
// Interrupt type classifier: maps a type code onto the follow-up action
// class and tells whether the end-of-interrupt busy poll may be skipped.
// Purely combinational; assumes the code is already isolated from the ISR.
module dskint_classify
    import dskint_pkg::*;
(
    input  logic [3:0] id,
    output act_e       act,
    output logic       skip_poll
);

    // Choose the action class for each type code
    always_comb begin
        case (id)
            4'd0, 4'd2, 4'd4:                           act = ACT_SPURIOUS;
            ID_OK, ID_OK_ECC, ID_OK_RETRY, ID_WARN:     act = ACT_DONE;
            ID_ABORTED, ID_RESET:                       act = ACT_QUIET;
            ID_XFER_RDY:                                act = ACT_DMA;
            ID_ATTN_ERR:                                act = ACT_FATAL;
            default:                                    act = ACT_FAIL;
        endcase
    end

    // Reset-done is acknowledged without waiting for the busy bit
    assign skip_poll = (id == ID_RESET);

endmodule

// File: rtl/dskint_stat_store.sv
// Status block store: DEPTH words, cleared as a whole at the start of each
// accepted interrupt, written one word at a time by index. Indices at or
// beyond DEPTH are dropped. Assumes clear and write never coincide.
module dskint_stat_store #(
    parameter int DEPTH = 8,
    parameter int W     = 16,
    parameter int IDX_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [W-1:0]       wr_data,
    output logic [DEPTH*W-1:0] blk
);

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_word
            logic [W-1:0] word_q;

            // Hold one status word; zero on reset or block clear
            always_ff @(posedge clk) begin
                if (!rst_n)
                    word_q <= '0;
                else if (clr)
                    word_q <= '0;
                else if (wr_en && (wr_idx == IDX_W'(g)))
                    word_q <= wr_data;
            end

            assign blk[g*W +: W] = word_q;
        end
    endgenerate

    // R5: a block clear and a word write are never requested together
    a_r5_clr_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr && wr_en));

endmodule

// File: rtl/dskint_eoi_seq.sv
// End-of-interrupt attention sequencer: disables attachment interrupts,
// waits for the busy bit to drop (unless told to skip), writes the
// end-of-interrupt attention for the drive, then re-enables interrupts.
// Assumes the owner hands it the register port while it is active.
module dskint_eoi_seq
    import dskint_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        dev,
    input  logic              skip_poll,
    input  logic [DATA_W-1:0] rdata,
    output logic              rd,
    output logic              wr,
    output logic [2:0]        addr,
    output logic [DATA_W-1:0] wdata,
    output logic              active,
    output logic              done
);

    typedef enum logic [2:0] {E_IDLE, E_OFF, E_POLL, E_ATN, E_ON} est_e;

    est_e        st;
    logic [2:0]  dev_q;
    logic        skip_q;

    // Step through the four-part handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= E_IDLE;
            dev_q  <= '0;
            skip_q <= 1'b0;
        end else begin
            case (st)
                E_IDLE: if (start) begin
                    st     <= E_OFF;
                    dev_q  <= dev;
                    skip_q <= skip_poll;
                end
                E_OFF:  st <= skip_q ? E_ATN : E_POLL;
                E_POLL: if (!rdata[SB_BUSY]) st <= E_ATN;
                E_ATN:  st <= E_ON;
                E_ON:   st <= E_IDLE;
                default: st <= E_IDLE;
            endcase
        end
    end

    // Drive the register port for the current step
    always_comb begin
        rd    = 1'b0;
        wr    = 1'b0;
        addr  = RA_STATUS;
        wdata = '0;
        case (st)
            E_OFF:  begin wr = 1'b1; addr = RA_CTRL; end
            E_POLL: begin rd = 1'b1; addr = RA_STATUS; end
            E_ATN:  begin wr = 1'b1; addr = RA_ATTN; wdata = DATA_W'({dev_q, ATTN_EOI}); end
            E_ON:   begin wr = 1'b1; addr = RA_CTRL; wdata = DATA_W'(CTRL_IEN); end
            default: ;
        endcase
    end

    assign active = (st != E_IDLE);
    assign done   = (st == E_ON);

    // R12: the attention write is always followed by interrupt re-enable
    a_r12_atn_then_on: assert property (@(posedge clk) disable iff (!rst_n)
        (st == E_ATN) |=> (st == E_ON));

    // R12: while the attachment reports busy, the poll step does not advance
    a_r12_poll_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st == E_POLL && rdata[SB_BUSY]) |=> (st == E_POLL));

endmodule

// File: rtl/dskint_handler.sv
// Disk attachment interrupt service engine (top). On an interrupt event it
// confirms the pending bit, decodes the interrupt status register, drains
// the status block, performs the type-specific action and, where needed,
// runs the end-of-interrupt handshake. Assumes a single-cycle register
// port whose read data is valid in the cycle of the read strobe.
module dskint_handler
    import dskint_pkg::*;
#(
    parameter int STAT_DEPTH = 8,
    parameter int DATA_W     = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         irq_evt,
    output logic                         att_rd,
    output logic                         att_wr,
    output logic [2:0]                   att_addr,
    output logic [DATA_W-1:0]            att_wdata,
    input  logic [DATA_W-1:0]            att_rdata,
    output logic                         busy,
    output logic                         cmd_done,
    output logic                         cmd_fail,
    output logic                         fatal,
    output logic                         len_ovf,
    output logic [DATA_W-1:0]            resid,
    output logic [2:0]                   last_dev,
    output logic [3:0]                   last_id,
    output logic [STAT_DEPTH*DATA_W-1:0] stat_blk
);

    localparam int LEN_W = DATA_W / 2;

    typedef enum logic [3:0] {
        S_IDLE, S_CHK, S_ISR, S_PEEK, S_W0, S_POLL, S_WN,
        S_ACT, S_DMA, S_EOI, S_FIN
    } st_e;

    st_e                state;
    act_e               act_q;
    act_e               cls_act;
    logic               cls_skip;
    logic               skip_q;
    logic [LEN_W-1:0]   len_q;
    logic [LEN_W-1:0]   cnt_q;
    logic [LEN_W-1:0]   len_raw;
    logic [4:0]         cmd_q;
    logic [DATA_W-1:0]  resw_q;

    logic               fsm_rd, fsm_wr;
    logic [2:0]         fsm_addr;
    logic [DATA_W-1:0]  fsm_wdata;

    logic               eoi_start, eoi_rd, eoi_wr, eoi_active, eoi_done;
    logic [2:0]         eoi_addr;
    logic [DATA_W-1:0]  eoi_wdata;

    logic               st_clr, st_wr;
    logic [LEN_W-1:0]   st_idx;

    assign len_raw = att_rdata[DATA_W-1 -: LEN_W];

    dskint_classify u_cls (
        .id        (att_rdata[3:0]),
        .act       (cls_act),
        .skip_poll (cls_skip)
    );

    // Main sequencing and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            act_q    <= ACT_SPURIOUS;
            skip_q   <= 1'b0;
            len_q    <= '0;
            cnt_q    <= '0;
            cmd_q    <= '0;
            resw_q   <= '0;
            cmd_done <= 1'b0;
            cmd_fail <= 1'b0;
            fatal    <= 1'b0;
            len_ovf  <= 1'b0;
            resid    <= '0;
            last_dev <= '0;
            last_id  <= '0;
        end else begin
            case (state)
                S_IDLE: if (irq_evt) state <= S_CHK;
                S_CHK:  state <= att_rdata[SB_PEND] ? S_ISR : S_IDLE;
                S_ISR: begin
                    if (cls_act == ACT_SPURIOUS) begin
                        state <= S_IDLE;
                    end else begin
                        state    <= S_PEEK;
                        act_q    <= cls_act;
                        skip_q   <= cls_skip;
                        last_dev <= att_rdata[7:5];
                        last_id  <= att_rdata[3:0];
                        cmd_q    <= '0;
                        resw_q   <= '0;
                        len_ovf  <= 1'b0;
                    end
                end
                S_PEEK: state <= att_rdata[SB_READY] ? S_W0 : S_ACT;
                S_W0: begin
                    cmd_q   <= att_rdata[4:0];
                    len_q   <= (len_raw == '0) ? LEN_W'(1) : len_raw;
                    len_ovf <= (len_raw > LEN_W'(STAT_DEPTH));
                    cnt_q   <= LEN_W'(1);
                    state   <= (len_raw > LEN_W'(1)) ? S_POLL : S_ACT;
                end
                S_POLL: if (att_rdata[SB_READY]) state <= S_WN;
                S_WN: begin
                    if (cnt_q == LEN_W'(RESID_WORD)) resw_q <= att_rdata;
                    cnt_q <= cnt_q + LEN_W'(1);
                    state <= ((cnt_q + LEN_W'(1)) >= len_q) ? S_ACT : S_POLL;
                end
                S_ACT: begin
                    case (act_q)
                        ACT_DMA:   state <= S_DMA;
                        ACT_FATAL: begin fatal <= 1'b1; state <= S_FIN; end
                        ACT_DONE:  begin cmd_done <= 1'b1; cmd_fail <= 1'b0; state <= S_EOI; end
                        ACT_FAIL:  begin cmd_fail <= 1'b1; cmd_done <= 1'b0; state <= S_EOI; end
                        default:   state <= S_EOI;
                    endcase
                end
                S_DMA:  state <= S_FIN;
                S_EOI:  if (eoi_done) state <= S_FIN;
                S_FIN: begin
                    if ((cmd_q == CMD_READ || cmd_q == CMD_WRITE) && act_q != ACT_DMA)
                        resid <= resw_q;
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Register port requests owned by the main sequencer
    always_comb begin
        fsm_rd    = 1'b0;
        fsm_wr    = 1'b0;
        fsm_addr  = RA_STATUS;
        fsm_wdata = '0;
        case (state)
            S_CHK, S_PEEK, S_POLL: begin fsm_rd = 1'b1; fsm_addr = RA_STATUS; end
            S_ISR:                 begin fsm_rd = 1'b1; fsm_addr = RA_ISR; end
            S_W0, S_WN:            begin fsm_rd = 1'b1; fsm_addr = RA_SWORD; end
            S_DMA: begin
                fsm_wr    = 1'b1;
                fsm_addr  = RA_CTRL;
                fsm_wdata = DATA_W'(CTRL_IEN | CTRL_DMA);
            end
            default: ;
        endcase
    end

    // Status store controls: clear on acceptance, write on each drained word
    assign st_clr = (state == S_ISR) && (cls_act != ACT_SPURIOUS);
    assign st_wr  = (state == S_W0) || ((state == S_WN) && (cnt_q < LEN_W'(STAT_DEPTH)));
    assign st_idx = (state == S_W0) ? '0 : cnt_q;

    dskint_stat_store #(
        .DEPTH (STAT_DEPTH),
        .W     (DATA_W),
        .IDX_W (LEN_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (st_clr),
        .wr_en   (st_wr),
        .wr_idx  (st_idx),
        .wr_data (att_rdata),
        .blk     (stat_blk)
    );

    // Hand-off of the end-of-interrupt handshake for acknowledged types
    assign eoi_start = (state == S_ACT) &&
                       (act_q == ACT_DONE || act_q == ACT_FAIL || act_q == ACT_QUIET);

    dskint_eoi_seq #(
        .DATA_W (DATA_W)
    ) u_eoi (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (eoi_start),
        .dev       (last_dev),
        .skip_poll (skip_q),
        .rdata     (att_rdata),
        .rd        (eoi_rd),
        .wr        (eoi_wr),
        .addr      (eoi_addr),
        .wdata     (eoi_wdata),
        .active    (eoi_active),
        .done      (eoi_done)
    );

    // Merge the two port users; only one is ever active
    assign att_rd    = fsm_rd | eoi_rd;
    assign att_wr    = fsm_wr | eoi_wr;
    assign att_addr  = eoi_active ? eoi_addr  : fsm_addr;
    assign att_wdata = eoi_active ? eoi_wdata : fsm_wdata;
    assign busy      = (state != S_IDLE);

    // R2: a clear pending bit ends service without touching the ISR
    a_r2_clear_flag_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CHK && !att_rdata[SB_PEND]) |=> (state == S_IDLE));

    // R4: spurious types return to idle right after the ISR read
    a_r4_spurious_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ISR && att_rdata[3:0] == 4'd2) |=> (state == S_IDLE));

    // R8 / R11: completion and failure status are never both shown
    a_r8_done_fail_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_done && cmd_fail));

    // R10: the fatal flag never drops without reset
    a_r10_fatal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fatal |=> fatal);

    // R7 / R10: no handshake starts while the engine is in the DMA step or fatal
    a_r7_no_eoi_on_dma: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DMA) |-> !eoi_active);

    // R12: the port is never read and written in the same cycle
    a_r12_port_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(att_rd && att_wr));

endmodule

// File: tb/dskint_handler_bench.sv
// Self-checking bench: behavioural attachment model, directed corner
// cases plus seeded random interrupts, expectations from bench functions.
module dskint_handler_bench;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_evt = 1'b0;
    logic        att_rd, att_wr;
    logic [2:0]  att_addr;
    logic [15:0] att_wdata, att_rdata;
    logic        busy, cmd_done, cmd_fail, fatal, len_ovf;
    logic [15:0] resid;
    logic [2:0]  last_dev;
    logic [3:0]  last_id;
    logic [DEPTH*16-1:0] stat_blk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    dskint_handler u_dskint_handler (
        .clk(clk), .rst_n(rst_n), .irq_evt(irq_evt),
        .att_rd(att_rd), .att_wr(att_wr), .att_addr(att_addr),
        .att_wdata(att_wdata), .att_rdata(att_rdata),
        .busy(busy), .cmd_done(cmd_done), .cmd_fail(cmd_fail),
        .fatal(fatal), .len_ovf(len_ovf), .resid(resid),
        .last_dev(last_dev), .last_id(last_id), .stat_blk(stat_blk)
    );

    // ---------------- attachment model ----------------
    logic        cfg_load = 1'b0;
    logic        cfg_pend;
    logic [7:0]  cfg_isr;
    logic        cfg_present;
    logic [15:0] cfg_fifo [0:15];
    int          cfg_nw, cfg_gap, cfg_busy;

    logic        m_pend;
    logic [7:0]  m_isr;
    logic        m_present;
    logic [15:0] m_fifo [0:15];
    int m_nw = 0, m_rp = 0, m_gap = 0, m_gapc = 0, m_busy = 0;
    int isr_rds = 0, sw_rds = 0, atn_busy = 0, wl_n = 0;
    logic [2:0]  wl_a [0:7];
    logic [15:0] wl_d [0:7];
    logic        m_ready;

    assign m_ready = m_present && (m_rp < m_nw) && (m_gapc == 0);

    always_comb begin
        case (att_addr)
            3'd0:    att_rdata = {13'b0, m_ready, (m_busy != 0), m_pend};
            3'd1:    att_rdata = {8'b0, m_isr};
            3'd2:    att_rdata = (m_rp < m_nw && m_rp < 16) ? m_fifo[m_rp] : 16'hDEAD;
            default: att_rdata = 16'h0;
        endcase
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cfg_load) begin
            m_pend <= cfg_pend; m_isr <= cfg_isr; m_present <= cfg_present;
            m_fifo <= cfg_fifo; m_nw <= cfg_nw; m_rp <= 0; m_gap <= cfg_gap;
            m_gapc <= 0; m_busy <= cfg_busy; isr_rds <= 0; sw_rds <= 0;
            atn_busy <= 0; wl_n <= 0;
        end else begin
            if (m_busy > 0) m_busy <= m_busy - 1;
            if (m_gapc > 0) m_gapc <= m_gapc - 1;
            if (att_rd && att_addr == 3'd1) begin m_pend <= 1'b0; isr_rds <= isr_rds + 1; end
            if (att_rd && att_addr == 3'd2) begin m_rp <= m_rp + 1; m_gapc <= m_gap; sw_rds <= sw_rds + 1; end
            if (att_wr) begin
                if (wl_n < 8) begin wl_a[wl_n] <= att_addr; wl_d[wl_n] <= att_wdata; end
                wl_n <= wl_n + 1;
                if (att_addr == 3'd4 && m_busy != 0) atn_busy <= atn_busy + 1;
            end
        end
    end

    // ---------------- expectation state ----------------
    logic        e_done = 0, e_fail = 0, e_fatal = 0, e_ovf = 0;
    logic [15:0] e_resid = 0;
    logic [2:0]  e_dev = 0;
    logic [3:0]  e_id = 0;
    logic [15:0] e_blk [0:DEPTH-1];

    // 0 spurious, 1 dma, 2 done, 3 quiet, 4 fatal, 5 fail
    function automatic int exp_act(input logic [3:0] id);
        case (id)
            4'd0, 4'd2, 4'd4:          return 0;
            4'd1, 4'd3, 4'd5, 4'd8:    return 2;
            4'd9, 4'd10:               return 3;
            4'd11:                     return 1;
            4'd15:                     return 4;
            default:                   return 5;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        check(cmd_done == e_done, {req, " cmd_done"}, 64'(cmd_done), 64'(e_done));
        check(cmd_fail == e_fail, {req, " cmd_fail"}, 64'(cmd_fail), 64'(e_fail));
        check(fatal == e_fatal,   {req, " fatal"},    64'(fatal),    64'(e_fatal));
        check(len_ovf == e_ovf,   {req, " len_ovf"},  64'(len_ovf),  64'(e_ovf));
        check(resid == e_resid,   {req, " resid"},    64'(resid),    64'(e_resid));
        check(last_dev == e_dev,  {req, " last_dev"}, 64'(last_dev), 64'(e_dev));
        check(last_id == e_id,    {req, " last_id"},  64'(last_id),  64'(e_id));
        for (int i = 0; i < DEPTH; i++)
            check(stat_blk[i*16 +: 16] == e_blk[i], {req, " stat_blk"},
                  64'(stat_blk[i*16 +: 16]), 64'(e_blk[i]));
    endtask

    // Apply one interrupt event and check every outcome
    task automatic run_vec(input string req, input logic pend, input logic [2:0] dev,
                           input logic [3:0] id, input logic present, input int len,
                           input logic [4:0] cmd, input int gap, input int bsy);
        logic [15:0] words [0:15];
        int eff, nw, a, n_exp;
        logic acc;
        logic [15:0] resw;
        logic [4:0]  ecmd;
        eff = (len == 0) ? 1 : len;
        nw  = present ? eff : 0;
        for (int i = 0; i < 16; i++) words[i] = 16'($urandom);
        words[0] = {8'(len), 3'($urandom), cmd};
        cfg_pend = pend; cfg_isr = {dev, 1'b0, id}; cfg_present = present;
        cfg_fifo = words; cfg_nw = nw; cfg_gap = gap; cfg_busy = bsy;
        // expectations
        a   = exp_act(id);
        acc = pend && (a != 0);
        if (acc) begin
            e_dev = dev; e_id = id; e_ovf = 1'b0; ecmd = 5'd0; resw = 16'd0;
            for (int i = 0; i < DEPTH; i++) e_blk[i] = 16'd0;
            if (present) begin
                for (int i = 0; i < DEPTH; i++) if (i < eff) e_blk[i] = words[i];
                e_ovf = (len > DEPTH); ecmd = cmd;
                resw = (eff > 2) ? words[2] : 16'd0;
            end
            if (a == 2) begin e_done = 1; e_fail = 0; end
            if (a == 5) begin e_fail = 1; e_done = 0; end
            if (a == 4) e_fatal = 1;
            if ((ecmd == 5'd1 || ecmd == 5'd2) && a != 1) e_resid = resw;
        end
        // stimulus
        @(negedge clk); cfg_load = 1'b1;
        @(negedge clk); cfg_load = 1'b0; irq_evt = 1'b1;
        @(negedge clk); irq_evt = 1'b0;
        for (int k = 0; k < 3000 && busy; k++) @(negedge clk);
        check(!busy, {req, " engine returned idle"}, 64'(busy), 64'd0);
        check_outputs(req);
        check(isr_rds == (pend ? 1 : 0), {req, " R2 ISR reads"}, 64'(isr_rds), 64'(pend ? 1 : 0));
        check(sw_rds == ((acc && present) ? nw : 0), {req, " R5 status word reads"},
              64'(sw_rds), 64'((acc && present) ? nw : 0));
        n_exp = (!acc || a == 4) ? 0 : (a == 1) ? 1 : 3;
        check(wl_n == n_exp, {req, " write count"}, 64'(wl_n), 64'(n_exp));
        if (acc && a == 1 && wl_n == 1)
            check(wl_a[0] == 3'd3 && wl_d[0] == 16'h0003, {req, " R7 dma enable write"},
                  64'({wl_a[0], wl_d[0]}), 64'({3'd3, 16'h0003}));
        if (acc && (a == 2 || a == 3 || a == 5) && wl_n == 3) begin
            check(wl_a[0] == 3'd3 && wl_d[0] == 16'h0, {req, " R12 ctrl off"},
                  64'({wl_a[0], wl_d[0]}), 64'({3'd3, 16'h0}));
            check(wl_a[1] == 3'd4 && wl_d[1] == {8'h0, dev, 5'd2}, {req, " R12 attention"},
                  64'({wl_a[1], wl_d[1]}), 64'({3'd4, 8'h0, dev, 5'd2}));
            check(wl_a[2] == 3'd3 && wl_d[2] == 16'h1, {req, " R12 ctrl on"},
                  64'({wl_a[2], wl_d[2]}), 64'({3'd3, 16'h1}));
        end
        if (acc && id != 4'd10)
            check(atn_busy == 0, {req, " R12 attention waits for not-busy"}, 64'(atn_busy), 64'd0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        e_done = 0; e_fail = 0; e_fatal = 0; e_ovf = 0; e_resid = 0; e_dev = 0; e_id = 0;
        for (int i = 0; i < DEPTH; i++) e_blk[i] = 16'd0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        wait (cyc >= 190000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=<190000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int dummy;
        dummy = $urandom(32'h5EED_1234);
        for (int i = 0; i < 16; i++) cfg_fifo[i] = 16'h0;
        cfg_pend = 0; cfg_isr = 0; cfg_present = 0; cfg_nw = 0; cfg_gap = 0; cfg_busy = 0;
        do_reset();
        // R1: reset state
        @(negedge clk);
        check(!busy && !att_rd && !att_wr, "R1 idle after reset", 64'({busy, att_rd, att_wr}), 64'd0);
        check_outputs("R1 reset");

        // R8 completion with read command, then R2 clear flag, R4 spurious types
        run_vec("R8 completion read", 1, 3'd1, 4'd1, 1, 4, 5'd1, 0, 0);
        run_vec("R2 pending clear", 0, 3'd5, 4'd12, 1, 3, 5'd2, 0, 0);
        run_vec("R4 spurious id0", 1, 3'd6, 4'd0, 1, 3, 5'd1, 0, 0);
        run_vec("R4 spurious id2", 1, 3'd2, 4'd2, 1, 3, 5'd1, 0, 0);
        run_vec("R4 spurious id4", 1, 3'd7, 4'd4, 1, 3, 5'd1, 0, 0);
        // R3 decode, R5 lengths with slow word arrival
        run_vec("R3 R5 len0", 1, 3'd7, 4'd3, 1, 0, 5'd2, 2, 0);
        run_vec("R5 len1", 1, 3'd4, 4'd5, 1, 1, 5'd9, 3, 0);
        run_vec("R13 len2 resid zero", 1, 3'd3, 4'd8, 1, 2, 5'd1, 1, 0);
        run_vec("R5 len8", 1, 3'd2, 4'd1, 1, 8, 5'd2, 2, 0);
        run_vec("R6 len9 overflow", 1, 3'd1, 4'd12, 1, 9, 5'd1, 1, 2);
        run_vec("R6 len11 overflow", 1, 3'd0, 4'd3, 1, 11, 5'd3, 3, 0);
        run_vec("R6 overflow cleared", 1, 3'd0, 4'd1, 1, 3, 5'd1, 0, 0);
        // R7 transfer ready keeps status and residual
        run_vec("R7 R13 transfer ready", 1, 3'd1, 4'd11, 1, 4, 5'd1, 0, 0);
        run_vec("R7 no block", 1, 3'd2, 4'd11, 0, 0, 5'd0, 0, 0);
        // R9 reset/abort, R12 busy poll and skip
        run_vec("R11 failure", 1, 3'd3, 4'd13, 1, 3, 5'd2, 0, 4);
        run_vec("R9 abort", 1, 3'd5, 4'd9, 1, 3, 5'd4, 0, 5);
        run_vec("R9 R12 reset skip poll", 1, 3'd6, 4'd10, 0, 0, 5'd0, 0, 30);
        check(atn_busy == 1, "R12 reset-done attention issued while busy", 64'(atn_busy), 64'd1);
        run_vec("R12 busy wait", 1, 3'd4, 4'd1, 1, 1, 5'd0, 0, 25);
        run_vec("R11 ecc plus retries", 1, 3'd2, 4'd7, 1, 2, 5'd0, 0, 0);
        run_vec("R8 warning", 1, 3'd2, 4'd8, 1, 5, 5'd2, 0, 0);

        // Random mix
        for (int v = 0; v < 300; v++) begin
            logic [3:0] rid;
            logic [4:0] rcmd;
            rid = 4'($urandom_range(0, 14));
            rcmd = ($urandom_range(0, 3) != 0) ? 5'($urandom_range(1, 2)) : 5'($urandom_range(0, 31));
            run_vec("R5 R8 R11 R13 random", ($urandom_range(0, 9) != 0), 3'($urandom),
                    rid, ($urandom_range(0, 4) != 0), $urandom_range(0, 11), rcmd,
                    $urandom_range(0, 3), $urandom_range(0, 6));
        end

        // R10 attention error is fatal and sticky until reset
        run_vec("R10 attention error", 1, 3'd3, 4'd15, 0, 0, 5'd0, 0, 0);
        run_vec("R10 fatal held", 1, 3'd1, 4'd1, 1, 3, 5'd1, 0, 0);
        do_reset();
        @(negedge clk);
        check(fatal == 1'b0, "R10 R1 fatal cleared by reset", 64'(fatal), 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule